// File: doc/BRIEF.md
# Register Rename Map with Free-List Allocation

This block is the rename stage of a single-issue out-of-order core. Each decoded instruction names up to two source registers and one destination from a small architectural register set. The block translates these names into a larger pool of physical registers. Both sources are looked up in a mapping table during the same cycle. When the instruction writes a register, it receives a fresh physical register from a FIFO of free physical registers, and the mapping table is updated. Because every write gets a new name, write-after-read and write-after-write conflicts disappear, and only true read-after-write links remain.

The physical register that the destination was mapped to before the update is reported. Downstream retirement logic can then hand that register back through the release port once no reader still needs it. When no free register is left for an instruction that needs one, the block raises stall and changes no state. Architectural register 0 can be configured as hardwired zero; it is then never renamed.

Top module: `reg_rename_stage`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The free list holds physical registers NUM_ARCH to NUM_PHYS-1 in ascending order, so the first allocation returns physical register NUM_ARCH (8 by default).
- R2: `psrc1` and `psrc2` show, in the same cycle and combinationally, the current mapping-table entries for `src1` and `src2`, whatever the state of `valid`.
- R3: An accepted allocation returns on `pdst` the oldest entry of the free list, and removes that entry at the next clock edge. Allocations therefore follow FIFO order.
- R4: After an accepted allocation, later reads of the destination's architectural register return the new physical register.
- R5: When a source and the destination of one instruction are the same architectural register, the source shows the mapping that held before this instruction.
- R6: On an accepted allocation, `old_pdst` shows the mapping the destination had before the update.
- R7: When `valid` and `has_dst` are high, the destination is renameable and the free list is empty, `stall` is high. In that cycle neither the mapping table nor the free list's allocation side changes.
- R8: A high `rel_valid` appends `rel_preg` to the tail of the free list. This holds when an allocation happens in the same cycle, and also when the list is empty (the stall decision in that cycle uses the list as it was).
- R9: With ZERO_REG_FIXED set (the default), architectural register 0 reads as physical register 0. A destination of 0 takes no register and does not stall, and `pdst` and `old_pdst` are 0.
- R10: When `valid` is low or `has_dst` is low, nothing is allocated: `pdst` and `old_pdst` are 0 and `stall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | A decoded instruction is presented |
| src1 | input | 3 | First architectural source |
| src2 | input | 3 | Second architectural source |
| dst | input | 3 | Architectural destination |
| has_dst | input | 1 | The instruction writes `dst` |
| rel_valid | input | 1 | Return a physical register to the free list |
| rel_preg | input | 4 | Physical register being returned |
| psrc1 | output | 4 | Physical name of `src1` |
| psrc2 | output | 4 | Physical name of `src2` |
| pdst | output | 4 | Newly allocated physical destination, 0 when none |
| old_pdst | output | 4 | Previous mapping of `dst`, 0 when no allocation |
| stall | output | 1 | No free register for a needed allocation |

## Verification
Two kinds of internal fault are visible at the ports. A corrupted mapping entry appears on `psrc1`/`psrc2` the first cycle that register is read. It also appears on `old_pdst` at the next write to that register. A fault in the free-list pointers or count appears as a wrong allocation order on `pdst`, or as a `stall` that arrives early or late. The run therefore walks the list all the way to empty. It also recycles released registers, so that a pointer that fails to wrap or a lost push shows up within a few allocations.

// File: rtl/rename_pkg.sv
package rename_pkg;

    // Decision taken by the rename control for the presented instruction.
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,   // nothing presented
        ACT_PASS  = 2'd1,   // presented, but no register to allocate
        ACT_ALLOC = 2'd2,   // allocate a fresh physical register
        ACT_STALL = 2'd3    // allocation needed, free list empty
    } rn_action_e;

    // Circular pointer advance for a buffer of 'depth' slots.
    function automatic int unsigned wrap_inc(input int unsigned ptr,
                                             input int unsigned depth);
        return (ptr + 1 == depth) ? 0 : ptr + 1;
    endfunction

endpackage

// File: rtl/rename_ctrl.sv
module rename_ctrl
    import rename_pkg::*;
#(
    parameter int AW             = 3,
    parameter bit ZERO_REG_FIXED = 1'b1
) (
    input  logic          valid,
    input  logic          has_dst,
    input  logic [AW-1:0] dst,
    input  logic          list_empty,
    output rn_action_e    action
);

    logic dst_renameable;

    generate
        if (ZERO_REG_FIXED) begin : g_zero_fixed
            assign dst_renameable = (dst != '0);
        end else begin : g_zero_free
            assign dst_renameable = 1'b1;
        end
    endgenerate

    always_comb begin
        if (!valid) begin
            action = ACT_IDLE;
        end else if (!has_dst || !dst_renameable) begin
            action = ACT_PASS;
        end else if (list_empty) begin
            action = ACT_STALL;
        end else begin
            action = ACT_ALLOC;
        end
    end

endmodule

// File: rtl/rename_map_table.sv
module rename_map_table #(
    parameter int NUM_ARCH       = 8,
    parameter int NUM_PHYS       = 16,
    parameter bit ZERO_REG_FIXED = 1'b1,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int PW = $clog2(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_a,
    input  logic [AW-1:0] rd_b,
    input  logic [AW-1:0] rd_c,
    output logic [PW-1:0] rd_a_val,
    output logic [PW-1:0] rd_b_val,
    output logic [PW-1:0] rd_c_val,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [PW-1:0] wr_val
);

    logic [PW-1:0] table_q [NUM_ARCH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ARCH; i++) begin
                table_q[i] <= PW'(i);
            end
        end else if (wr_en) begin
            if (!(ZERO_REG_FIXED && wr_addr == '0)) begin
                table_q[wr_addr] <= wr_val;
            end
        end
    end

    // Reads see the table before this cycle's write.
    always_comb begin
        rd_a_val = table_q[rd_a];
        rd_b_val = table_q[rd_b];
        rd_c_val = table_q[rd_c];
        if (ZERO_REG_FIXED) begin
            if (rd_a == '0) rd_a_val = '0;
            if (rd_b == '0) rd_b_val = '0;
            if (rd_c == '0) rd_c_val = '0;
        end
    end

endmodule

// File: rtl/rename_free_fifo.sv
module rename_free_fifo
    import rename_pkg::*;
#(
    parameter int NUM_ARCH = 8,
    parameter int NUM_PHYS = 16,
    localparam int PW    = $clog2(NUM_PHYS),
    localparam int CW    = $clog2(NUM_PHYS + 1),
    localparam int NINIT = NUM_PHYS - NUM_ARCH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pop,
    input  logic          push,
    input  logic [PW-1:0] push_val,
    output logic [PW-1:0] head_val,
    output logic          empty,
    output logic [CW-1:0] count
);

    logic [PW-1:0] slots_q [NUM_PHYS];
    logic [PW-1:0] head_q, tail_q;
    logic [CW-1:0] count_q;
    logic          do_pop, do_push;

    assign empty    = (count_q == '0);
    assign head_val = slots_q[head_q];
    assign count    = count_q;
    assign do_pop   = pop && !empty;
    assign do_push  = push && ((count_q != CW'(NUM_PHYS)) || do_pop);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_PHYS; i++) begin
                slots_q[i] <= (i < NINIT) ? PW'(NUM_ARCH + i) : '0;
            end
            head_q  <= '0;
            tail_q  <= PW'(NINIT % NUM_PHYS);
            count_q <= CW'(NINIT);
        end else begin
            if (do_push) begin
                slots_q[tail_q] <= push_val;
                tail_q          <= PW'(wrap_inc(int'(tail_q), NUM_PHYS));
            end
            if (do_pop) begin
                head_q <= PW'(wrap_inc(int'(head_q), NUM_PHYS));
            end
            case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

endmodule

// File: rtl/reg_rename_stage.sv
module reg_rename_stage
    import rename_pkg::*;
#(
    parameter int NUM_ARCH       = 8,
    parameter int NUM_PHYS       = 16,
    parameter bit ZERO_REG_FIXED = 1'b1,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int PW = $clog2(NUM_PHYS),
    localparam int CW = $clog2(NUM_PHYS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    input  logic [AW-1:0] src1,
    input  logic [AW-1:0] src2,
    input  logic [AW-1:0] dst,
    input  logic          has_dst,
    input  logic          rel_valid,
    input  logic [PW-1:0] rel_preg,
    output logic [PW-1:0] psrc1,
    output logic [PW-1:0] psrc2,
    output logic [PW-1:0] pdst,
    output logic [PW-1:0] old_pdst,
    output logic          stall
);

    rn_action_e    action;
    logic          list_empty;
    logic [PW-1:0] list_head;
    logic [CW-1:0] free_count;
    logic [PW-1:0] dst_prev;
    logic          alloc_fire;

    rename_ctrl #(
        .AW             (AW),
        .ZERO_REG_FIXED (ZERO_REG_FIXED)
    ) u_ctrl (
        .valid      (valid),
        .has_dst    (has_dst),
        .dst        (dst),
        .list_empty (list_empty),
        .action     (action)
    );

    assign alloc_fire = (action == ACT_ALLOC);

    rename_map_table #(
        .NUM_ARCH       (NUM_ARCH),
        .NUM_PHYS       (NUM_PHYS),
        .ZERO_REG_FIXED (ZERO_REG_FIXED)
    ) u_map (
        .clk      (clk),
        .rst      (rst),
        .rd_a     (src1),
        .rd_b     (src2),
        .rd_c     (dst),
        .rd_a_val (psrc1),
        .rd_b_val (psrc2),
        .rd_c_val (dst_prev),
        .wr_en    (alloc_fire),
        .wr_addr  (dst),
        .wr_val   (list_head)
    );

    rename_free_fifo #(
        .NUM_ARCH (NUM_ARCH),
        .NUM_PHYS (NUM_PHYS)
    ) u_free (
        .clk      (clk),
        .rst      (rst),
        .pop      (alloc_fire),
        .push     (rel_valid),
        .push_val (rel_preg),
        .head_val (list_head),
        .empty    (list_empty),
        .count    (free_count)
    );

    assign pdst     = alloc_fire ? list_head : '0;
    assign old_pdst = alloc_fire ? dst_prev  : '0;
    assign stall    = (action == ACT_STALL);

endmodule

// File: rtl/rename_checker.sv
module rename_checker #(
    parameter int NUM_PHYS = 16,
    parameter int AW       = 3,
    parameter int PW       = 4,
    parameter int CW       = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          valid,
    input logic          has_dst,
    input logic [AW-1:0] src1,
    input logic [AW-1:0] dst,
    input logic          rel_valid,
    input logic [PW-1:0] psrc1,
    input logic [PW-1:0] pdst,
    input logic [PW-1:0] old_pdst,
    input logic          stall,
    input logic [CW-1:0] free_count,
    input logic          alloc_fire
);

    // R7: a stall only happens with an empty list, and it removes nothing.
    assert_stall_empty_R7: assert property (@(posedge clk) disable iff (rst)
        stall |-> (free_count == '0));
    assert_stall_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (stall && !rel_valid) |=> (free_count == '0));

    // R3: an allocation without a release shrinks the list by one.
    assert_alloc_pops_R3: assert property (@(posedge clk) disable iff (rst)
        (alloc_fire && !rel_valid) |=> (free_count == $past(free_count) - 1'b1));

    // R8: a release grows the list unless an allocation balances it.
    assert_release_pushes_R8: assert property (@(posedge clk) disable iff (rst)
        (rel_valid && !alloc_fire && free_count != CW'(NUM_PHYS))
        |=> (free_count == $past(free_count) + 1'b1));
    assert_release_balanced_R8: assert property (@(posedge clk) disable iff (rst)
        (rel_valid && alloc_fire) |=> (free_count == $past(free_count)));

    // R6: the new name never equals the name it replaces.
    assert_fresh_name_R6: assert property (@(posedge clk) disable iff (rst)
        alloc_fire |-> (pdst != old_pdst));

    // R9: architectural register 0 stays physical 0.
    assert_zero_src_R9: assert property (@(posedge clk) disable iff (rst)
        (src1 == '0) |-> (psrc1 == '0));
    assert_zero_dst_R9: assert property (@(posedge clk) disable iff (rst)
        (valid && has_dst && dst == '0) |-> (!stall && pdst == '0));

    // R10: nothing presented means nothing allocated.
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (!valid || !has_dst) |-> (pdst == '0 && old_pdst == '0 && !stall));

endmodule

bind reg_rename_stage rename_checker #(
    .NUM_PHYS (NUM_PHYS),
    .AW       (AW),
    .PW       (PW),
    .CW       (CW)
) u_rename_chk (
    .clk        (clk),
    .rst        (rst),
    .valid      (valid),
    .has_dst    (has_dst),
    .src1       (src1),
    .dst        (dst),
    .rel_valid  (rel_valid),
    .psrc1      (psrc1),
    .pdst       (pdst),
    .old_pdst   (old_pdst),
    .stall      (stall),
    .free_count (free_count),
    .alloc_fire (alloc_fire)
);

// File: tb/tb_reg_rename_stage.sv
module tb_reg_rename_stage;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst;
    logic       valid, has_dst, rel_valid;
    logic [2:0] src1, src2, dst;
    logic [3:0] rel_preg;
    logic [3:0] psrc1, psrc2, pdst, old_pdst;
    logic       stall;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reg_rename_stage dut (
        .clk (clk), .rst (rst), .valid (valid), .src1 (src1), .src2 (src2),
        .dst (dst), .has_dst (has_dst), .rel_valid (rel_valid), .rel_preg (rel_preg),
        .psrc1 (psrc1), .psrc2 (psrc2), .pdst (pdst), .old_pdst (old_pdst),
        .stall (stall)
    );

    typedef struct packed {
        logic       v;
        logic [2:0] s1;
        logic [2:0] s2;
        logic [2:0] d;
        logic       hd;
        logic       rv;
        logic [3:0] rp;
        logic [3:0] e1;
        logic [3:0] e2;
        logic [3:0] ep;
        logic [3:0] eo;
        logic       es;
    } vec_t;

    // Run from reset; free list starts 8,9,...,15.
    localparam vec_t VECS [8] = '{
        // v  s1    s2    d     hd   rv   rp     e1     e2     ep     eo     es
        '{1'b1,3'd3,3'd3,3'd3,1'b1,1'b0,4'd0, 4'd3, 4'd3, 4'd8, 4'd3, 1'b0}, // R5 R3 R6
        '{1'b1,3'd3,3'd1,3'd1,1'b1,1'b0,4'd0, 4'd8, 4'd1, 4'd9, 4'd1, 1'b0}, // R4
        '{1'b1,3'd1,3'd2,3'd3,1'b1,1'b0,4'd0, 4'd9, 4'd2, 4'd10,4'd8, 1'b0}, // R6
        '{1'b1,3'd0,3'd3,3'd0,1'b1,1'b0,4'd0, 4'd0, 4'd10,4'd0, 4'd0, 1'b0}, // R9
        '{1'b1,3'd3,3'd1,3'd5,1'b0,1'b0,4'd0, 4'd10,4'd9, 4'd0, 4'd0, 1'b0}, // R10
        '{1'b0,3'd2,3'd3,3'd2,1'b1,1'b0,4'd0, 4'd2, 4'd10,4'd0, 4'd0, 1'b0}, // R10 R2
        '{1'b0,3'd0,3'd0,3'd0,1'b0,1'b1,4'd3, 4'd0, 4'd0, 4'd0, 4'd0, 1'b0}, // R8
        '{1'b1,3'd2,3'd2,3'd2,1'b1,1'b1,4'd8, 4'd2, 4'd2, 4'd11,4'd2, 1'b0}  // R8 R3
    };

    task automatic check(input string req, input string what,
                         input logic [3:0] got, input logic [3:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [2:0] s1, input logic [2:0] s2,
                         input logic [2:0] d, input logic hd,
                         input logic rv, input logic [3:0] rp);
        valid = v; src1 = s1; src2 = s2; dst = d; has_dst = hd;
        rel_valid = rv; rel_preg = rp;
    endtask

    // Drive just after a rising edge, sample at the falling edge.
    task automatic present(input logic v, input logic [2:0] s1, input logic [2:0] s2,
                           input logic [2:0] d, input logic hd,
                           input logic rv, input logic [3:0] rp);
        @(posedge clk);
        #1;
        drive(v, s1, s2, d, hd, rv, rp);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst = 1'b1;
        drive(1'b0, 3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 4'd0);
        @(posedge clk);
        @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        drive(1'b0, 3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 4'd0);
        do_reset();

        // R1: identity map and first free register after reset.
        present(1'b1, 3'd7, 3'd4, 3'd6, 1'b0, 1'b0, 4'd0);
        check("R1", "psrc1 of r7", psrc1, 4'd7);
        check("R1", "psrc2 of r4", psrc2, 4'd4);
        check("R10", "pdst without dst", pdst, 4'd0);

        // Table walk.
        for (int i = 0; i < 8; i++) begin
            present(VECS[i].v, VECS[i].s1, VECS[i].s2, VECS[i].d, VECS[i].hd,
                    VECS[i].rv, VECS[i].rp);
            check("R2", $sformatf("vec%0d psrc1", i), psrc1, VECS[i].e1);
            check("R2", $sformatf("vec%0d psrc2", i), psrc2, VECS[i].e2);
            check("R3", $sformatf("vec%0d pdst", i), pdst, VECS[i].ep);
            check("R6", $sformatf("vec%0d old_pdst", i), old_pdst, VECS[i].eo);
            check("R7", $sformatf("vec%0d stall", i), {3'd0, stall}, {3'd0, VECS[i].es});
        end

        // R3: drain the rest of the list in FIFO order: 12,13,14,15,3,8.
        begin
            logic [3:0] order [6];
            logic [3:0] prev;
            order = '{4'd12, 4'd13, 4'd14, 4'd15, 4'd3, 4'd8};
            prev = 4'd4;
            for (int k = 0; k < 6; k++) begin
                present(1'b1, 3'd4, 3'd0, 3'd4, 1'b1, 1'b0, 4'd0);
                check("R3", $sformatf("drain %0d pdst", k), pdst, order[k]);
                check("R6", $sformatf("drain %0d old_pdst", k), old_pdst, prev);
                check("R4", $sformatf("drain %0d psrc1", k), psrc1, prev);
                prev = order[k];
            end
        end

        // R7: empty list with a destination stalls and changes no mapping.
        present(1'b1, 3'd5, 3'd4, 3'd5, 1'b1, 1'b0, 4'd0);
        check("R7", "stall when empty", {3'd0, stall}, 4'd1);
        check("R7", "pdst when stalled", pdst, 4'd0);
        present(1'b1, 3'd5, 3'd4, 3'd5, 1'b1, 1'b0, 4'd0);
        check("R7", "r5 mapping kept", psrc1, 4'd5);
        check("R7", "still stalled", {3'd0, stall}, 4'd1);
        present(1'b1, 3'd5, 3'd4, 3'd5, 1'b0, 1'b0, 4'd0);
        check("R10", "no dst while empty", {3'd0, stall}, 4'd0);
        present(1'b1, 3'd0, 3'd4, 3'd0, 1'b1, 1'b0, 4'd0);
        check("R9", "dst r0 while empty", {3'd0, stall}, 4'd0);

        // R8: release while empty, in the same cycle as a stalled request.
        present(1'b1, 3'd5, 3'd4, 3'd5, 1'b1, 1'b1, 4'd1);
        check("R8", "stall uses list before release", {3'd0, stall}, 4'd1);
        present(1'b1, 3'd5, 3'd4, 3'd5, 1'b1, 1'b0, 4'd0);
        check("R8", "released register allocated", pdst, 4'd1);
        check("R6", "old of r5", old_pdst, 4'd5);
        check("R7", "no stall after release", {3'd0, stall}, 4'd0);
        present(1'b0, 3'd5, 3'd0, 3'd0, 1'b0, 1'b0, 4'd0);
        check("R4", "r5 renamed", psrc1, 4'd1);

        // R1: reset restores identity and restarts the list at 8.
        do_reset();
        present(1'b1, 3'd3, 3'd5, 3'd6, 1'b1, 1'b0, 4'd0);
        check("R1", "r3 after reset", psrc1, 4'd3);
        check("R1", "r5 after reset", psrc2, 4'd5);
        check("R1", "first alloc after reset", pdst, 4'd8);
        check("R1", "old of r6 after reset", old_pdst, 4'd6);

        @(posedge clk);
        #1;
        drive(1'b0, 3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 4'd0);
        @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) begin
            @(posedge clk);
        end
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule